// File: doc/BRIEF.md
# Strap-Configured Management Access Decoder

This block sits behind a management-bus frame front end on a switch-style device. Each cycle it may receive one decoded transaction: a valid strobe, a write flag, a 5-bit bus address, a 5-bit register number and 16 bits of write data. It decides whether the device claims that transaction. It forwards claimed transactions to an internal register bus that reaches up to 32 internal devices, each holding 32 registers. For every transaction it returns a response strobe, a claim flag and a read word.

The access mode comes from strap inputs that are captured while reset is held. The strap supplies bits 4:1 of the device's own bus address; bit 0 of that address is always zero.

- **Flat mode** (strap all zero): every bus address is claimed, and the bus address names the internal device directly.
- **Split mode**: only the top strap bit matters. The device claims the half of the address space selected by that bit, so two devices can share one bus. The internal device index is the bus address minus the base of that half.
- **Tunnelled mode** (strap non-zero, split not selected): the device claims only its own address and exposes two registers there.
  - Register 0 is a command register. Setting its busy bit starts an internal access.
  - Register 1 is a data register. It holds write data going in and read results coming back.

Top module: `mgmt_access_decoder`

## Requirements
- R1: The mode is taken from `strap_addr_hi` and `strap_split` during reset and held until the next reset. `strap_split`=1 selects split mode, an all-zero strap selects flat mode, and anything else selects tunnelled mode. Right after reset, `rsp_valid`, `rsp_claim` and `ib_valid` are 0 and `rsp_rdata` is 16'hFFFF.
- R2: In flat mode every address is claimed. A request sampled at edge E drives `ib_valid` with `ib_dev` = the bus address, `ib_reg` and `ib_wdata` in the cycle after E. Every request gets `rsp_valid` in the cycle after E+1, and a claimed read returns the `ib_rdata` presented during the access cycle.
- R3: In split mode an address is claimed only when its bit 4 equals strap bit 4. `ib_dev` is the address minus 16 when that bit is 1, and the address itself when it is 0.
- R4: An unclaimed request gives `rsp_claim`=0 and `rsp_rdata`=16'hFFFF and makes no internal access. A claimed write also returns 16'hFFFF.
- R5: In tunnelled mode only address {strap_addr_hi,0} is claimed. At that address, register 0 is the command register and register 1 is the data register. Registers 2 to 31 read 0 and ignore writes.
- R6: A command word is laid out as follows: bit 15 is busy/start, bit 12 marks a clause-22 access, bits 11:10 are the opcode (01 = write, 10 = read), bits 9:5 are the internal device and bits 4:0 the internal register. A command read returns the busy state in bit 15 and the stored bits 14:0.
- R7: A command written with bit 15 set makes busy read as 1 in exactly LAT consecutive cycles, starting with the cycle after the write is sampled. Busy then reads 0.
- R8: A tunnelled write drives the data register contents to the commanded device and register on the internal bus, once.
- R9: After a tunnelled read completes, the data register holds the word the internal bus returned.
- R10: A command whose bit 12 is 0, or whose opcode is 00 or 11, makes no internal access, leaves the data register unchanged, and still clears busy after LAT cycles.
- R11: A command write while busy is 1 is ignored.
- R12: A data register write while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_addr_hi | input | 4 | Strapped device address bits 4:1 |
| strap_split | input | 1 | Strap selecting split mode |
| req_valid | input | 1 | Decoded transaction present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Bus device address |
| req_reg | input | 5 | Bus register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_claim | output | 1 | The transaction was claimed |
| rsp_rdata | output | 16 | Read data, 16'hFFFF when not a claimed read |
| ib_valid | output | 1 | Internal bus access strobe |
| ib_write | output | 1 | Internal access is a write |
| ib_dev | output | 5 | Internal device index |
| ib_reg | output | 5 | Internal register index |
| ib_wdata | output | 16 | Internal write data |
| ib_rdata | input | 16 | Internal read data, valid in the cycle `ib_valid` is high |

## Verification
The assertions assume that the strap inputs are meaningful only while reset is high. They also assume that the internal bus returns read data combinationally in the same cycle as `ib_valid`, and that at most one request arrives per cycle. The bench changes the straps only around a reset, except in one deliberate test that changes them afterwards. It models the internal devices as an array that answers in the access cycle and presents each transaction for a single cycle. Tunnelled sequences follow the intended software order: load the data register, write the command, then poll busy. The only departures are the requests deliberately issued while busy to test that they are ignored.

// File: rtl/mgmt_dec_pkg.sv
package mgmt_dec_pkg;
  typedef enum logic [1:0] {
    MODE_FLAT     = 2'd0,
    MODE_SPLIT    = 2'd1,
    MODE_TUNNELED = 2'd2
  } acc_mode_e;

  // command word field positions (software decodes these)
  localparam int CMD_START_BIT = 15;
  localparam int CMD_C22_BIT   = 12;
  localparam int CMD_OP_LSB    = 10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  // tunnelled register numbers at the device's own address
  localparam int REG_CMD  = 0;
  localparam int REG_DATA = 1;
endpackage

// File: rtl/strap_mode_latch.sv
module strap_mode_latch
  import mgmt_dec_pkg::*;
#(
  parameter int STRAP_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_hi,
  input  logic               strap_split,
  output acc_mode_e          mode,
  output logic [STRAP_W:0]   own_addr
);
  // follow the straps while reset is held; freeze on release
  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= {strap_hi, 1'b0};
      if (strap_split)         mode <= MODE_SPLIT;
      else if (strap_hi == '0) mode <= MODE_FLAT;
      else                     mode <= MODE_TUNNELED;
    end
  end

  assert_mode_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(mode) && $stable(own_addr)))
    else $error("mode changed outside reset");
endmodule

// File: rtl/addr_claim.sv
module addr_claim
  import mgmt_dec_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  acc_mode_e         mode,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] phy,
  output logic              claim,
  output logic [ADDR_W-1:0] dev
);
  localparam logic [ADDR_W-1:0] HALF_MASK = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [ADDR_W-1:0] half_base;
  assign half_base = own_addr & HALF_MASK;

  always_comb begin
    claim = 1'b0;
    dev   = phy;
    unique case (mode)
      MODE_FLAT: claim = 1'b1;
      MODE_SPLIT: begin
        claim = (phy[ADDR_W-1] == own_addr[ADDR_W-1]);
        dev   = phy - half_base;
      end
      MODE_TUNNELED: claim = (phy == own_addr);
      default: claim = 1'b0;
    endcase
  end
endmodule

// File: rtl/tunnel_engine.sv
module tunnel_engine
  import mgmt_dec_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,   // command layout needs at least 16
  parameter int LAT    = 4     // busy cycles per command, at least 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ib_rdata,
  output logic [DATA_W-1:0] cmd_word,
  output logic [DATA_W-1:0] data_word,
  output logic              busy,
  output logic              ib_valid,
  output logic              ib_write,
  output logic [ADDR_W-1:0] ib_dev,
  output logic [ADDR_W-1:0] ib_reg,
  output logic [DATA_W-1:0] ib_wdata
);
  localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  logic [DATA_W-2:0] cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        op;
  logic              op_ok;

  assign op        = cmd_q[CMD_OP_LSB +: 2];
  assign op_ok     = cmd_q[CMD_C22_BIT] && (op == OP_WR || op == OP_RD);
  assign cmd_word  = {busy, cmd_q};
  assign data_word = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cmd_q    <= '0;
      data_q   <= '0;
      ib_valid <= 1'b0;
      ib_write <= 1'b0;
      ib_dev   <= '0;
      ib_reg   <= '0;
      ib_wdata <= '0;
    end else begin
      ib_valid <= 1'b0;
      if (!busy) begin
        if (cmd_we) begin
          cmd_q <= wdata[DATA_W-2:0];
          if (wdata[CMD_START_BIT]) begin
            busy <= 1'b1;
            cnt  <= CNT_LOAD;
          end
        end else if (data_we) begin
          data_q <= wdata;
        end
      end else begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1) && op_ok) begin
          ib_valid <= 1'b1;
          ib_write <= (op == OP_WR);
          ib_dev   <= cmd_q[ADDR_W +: ADDR_W];
          ib_reg   <= cmd_q[0 +: ADDR_W];
          ib_wdata <= data_q;
        end
        if (cnt == '0) begin
          busy <= 1'b0;
          if (op_ok && op == OP_RD) data_q <= ib_rdata;
        end
      end
    end
  end

  assert_start_needs_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_we && wdata[CMD_START_BIT]))
    else $error("busy rose without a start command");

  assert_access_inside_busy_R7: assert property (@(posedge clk) disable iff (rst)
    ib_valid |-> busy)
    else $error("internal access outside busy window");

  assert_bad_op_no_access_R10: assert property (@(posedge clk) disable iff (rst)
    ib_valid |-> (cmd_q[CMD_C22_BIT] && (ib_write == (op == OP_WR))))
    else $error("internal access for an invalid command");

  assert_cmd_locked_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_q))
    else $error("command changed while busy");

  assert_data_locked_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(data_q))
    else $error("data register changed while busy");
endmodule

// File: rtl/mgmt_access_decoder.sv
module mgmt_access_decoder
  import mgmt_dec_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        strap_addr_hi,
  input  logic              strap_split,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ib_valid,
  output logic              ib_write,
  output logic [ADDR_W-1:0] ib_dev,
  output logic [ADDR_W-1:0] ib_reg,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic [DATA_W-1:0] ib_rdata
);
  localparam int STRAP_W = ADDR_W - 1;

  acc_mode_e         mode;
  logic [ADDR_W-1:0] own_addr;
  logic              claim;
  logic [ADDR_W-1:0] dec_dev;
  logic              tunneled;
  logic              cmd_we, data_we;
  logic [DATA_W-1:0] cmd_word, data_word;
  logic              eng_busy;
  logic              e_valid, e_write;
  logic [ADDR_W-1:0] e_dev, e_reg;
  logic [DATA_W-1:0] e_wdata;

  // direct path internal bus registers
  logic              d_valid, d_write;
  logic [ADDR_W-1:0] d_dev, d_reg;
  logic [DATA_W-1:0] d_wdata;

  // first response stage
  logic              s1_valid, s1_claim, s1_read, s1_from_ib;
  logic [DATA_W-1:0] s1_snap;

  strap_mode_latch #(.STRAP_W(STRAP_W)) u_straps (
    .clk(clk), .rst(rst), .strap_hi(strap_addr_hi[STRAP_W-1:0]),
    .strap_split(strap_split), .mode(mode), .own_addr(own_addr)
  );

  addr_claim #(.ADDR_W(ADDR_W)) u_claim (
    .mode(mode), .own_addr(own_addr), .phy(req_phy),
    .claim(claim), .dev(dec_dev)
  );

  assign tunneled = (mode == MODE_TUNNELED);
  assign cmd_we   = req_valid && claim && tunneled && req_write &&
                    (req_reg == ADDR_W'(REG_CMD));
  assign data_we  = req_valid && claim && tunneled && req_write &&
                    (req_reg == ADDR_W'(REG_DATA));

  tunnel_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_engine (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .data_we(data_we),
    .wdata(req_wdata), .ib_rdata(ib_rdata),
    .cmd_word(cmd_word), .data_word(data_word), .busy(eng_busy),
    .ib_valid(e_valid), .ib_write(e_write), .ib_dev(e_dev),
    .ib_reg(e_reg), .ib_wdata(e_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      d_valid    <= 1'b0;
      d_write    <= 1'b0;
      d_dev      <= '0;
      d_reg      <= '0;
      d_wdata    <= '0;
      s1_valid   <= 1'b0;
      s1_claim   <= 1'b0;
      s1_read    <= 1'b0;
      s1_from_ib <= 1'b0;
      s1_snap    <= '0;
      rsp_valid  <= 1'b0;
      rsp_claim  <= 1'b0;
      rsp_rdata  <= '1;
    end else begin
      d_valid    <= req_valid && claim && !tunneled;
      d_write    <= req_write;
      d_dev      <= dec_dev;
      d_reg      <= req_reg;
      d_wdata    <= req_wdata;

      s1_valid   <= req_valid;
      s1_claim   <= claim;
      s1_read    <= !req_write;
      s1_from_ib <= !tunneled;
      if (req_reg == ADDR_W'(REG_CMD))       s1_snap <= cmd_word;
      else if (req_reg == ADDR_W'(REG_DATA)) s1_snap <= data_word;
      else                                   s1_snap <= '0;

      rsp_valid  <= s1_valid;
      rsp_claim  <= s1_valid && s1_claim;
      if (s1_valid && s1_claim && s1_read)
        rsp_rdata <= s1_from_ib ? ib_rdata : s1_snap;
      else
        rsp_rdata <= '1;
    end
  end

  assign ib_valid = tunneled ? e_valid : d_valid;
  assign ib_write = tunneled ? e_write : d_write;
  assign ib_dev   = tunneled ? e_dev   : d_dev;
  assign ib_reg   = tunneled ? e_reg   : d_reg;
  assign ib_wdata = tunneled ? e_wdata : d_wdata;

  assert_flat_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLAT && ib_valid) |-> $past(req_valid))
    else $error("flat access without a request one cycle earlier");

  assert_split_range_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SPLIT && ib_valid) |-> !ib_dev[ADDR_W-1])
    else $error("split mode device index out of half range");

  assert_unclaimed_word_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_claim) |-> (rsp_rdata == '1))
    else $error("unclaimed response not all ones");

  assert_claim_with_rsp_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_claim |-> rsp_valid)
    else $error("claim flag without response");
endmodule

// File: tb/tb_mgmt_access_decoder.sv
`timescale 1ns/1ps
module tb_mgmt_access_decoder;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  strap_addr_hi;
  logic        strap_split;
  logic        req_valid, req_write;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        rsp_valid, rsp_claim;
  logic [15:0] rsp_rdata;
  logic        ib_valid, ib_write;
  logic [4:0]  ib_dev, ib_reg;
  logic [15:0] ib_wdata, ib_rdata;

  int checks = 0;
  int fails  = 0;
  int ib_count;
  logic [15:0] mem [0:1023];

  always #10 clk = ~clk;

  mgmt_access_decoder #(.LAT(LAT)) dut (
    .clk(clk), .rst(rst), .strap_addr_hi(strap_addr_hi), .strap_split(strap_split),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_claim(rsp_claim), .rsp_rdata(rsp_rdata), .ib_valid(ib_valid),
    .ib_write(ib_write), .ib_dev(ib_dev), .ib_reg(ib_reg),
    .ib_wdata(ib_wdata), .ib_rdata(ib_rdata)
  );

  function automatic logic [15:0] pat(input int idx);
    return 16'(idx * 37) ^ 16'hC3A0;
  endfunction

  // internal device model: answers in the access cycle
  assign ib_rdata = mem[{ib_dev, ib_reg}];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      ib_count <= 0;
    end else if (ib_valid) begin
      ib_count <= ib_count + 1;
      if (ib_write) mem[{ib_dev, ib_reg}] <= ib_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] s, input logic sp);
    @(negedge clk);
    rst = 1'b1; strap_addr_hi = s; strap_split = sp;
    req_valid = 1'b0; req_write = 1'b0; req_phy = '0; req_reg = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one request; response sampled two edges after the request edge
  task automatic send(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wd, output logic cl, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    cl = rsp_claim; rd = rsp_rdata;
  endtask

  task automatic poll_idle(input logic [4:0] own, input string tag);
    logic cl; logic [15:0] rd;
    bit done = 0;
    for (int i = 0; i < 20 && !done; i++) begin
      send(1'b0, own, 5'd0, 16'h0, cl, rd);
      if (!rd[15]) done = 1;
    end
    check(done, tag, 0, 1);
  endtask

  task automatic t_reset;
    do_reset(4'd0, 1'b0);
    @(negedge clk);
    check(rsp_valid == 0 && rsp_claim == 0 && ib_valid == 0, "R1 reset strobes",
          {rsp_valid, rsp_claim, ib_valid}, 0);
    check(rsp_rdata == 16'hFFFF, "R1 reset rdata", rsp_rdata, 16'hFFFF);
  endtask

  task automatic t_flat;
    logic cl; logic [15:0] rd;
    do_reset(4'd0, 1'b0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_phy = 5'd7; req_reg = 5'd9; req_wdata = 16'hBEEF;
    @(negedge clk);
    req_valid = 0;
    check(ib_valid && ib_write && ib_dev == 7 && ib_reg == 9 && ib_wdata == 16'hBEEF,
          "R2 flat write on bus next cycle", {ib_valid, ib_dev, ib_reg}, {1'b1, 5'd7, 5'd9});
    @(negedge clk);
    check(rsp_valid && rsp_claim && rsp_rdata == 16'hFFFF, "R4 claimed write word",
          rsp_rdata, 16'hFFFF);
    send(1'b0, 5'd7, 5'd9, 16'h0, cl, rd);
    check(cl && rd == 16'hBEEF, "R2 flat readback", rd, 16'hBEEF);
    send(1'b0, 5'd31, 5'd31, 16'h0, cl, rd);
    check(cl && rd == pat(1023), "R2 flat top address", rd, pat(1023));
    strap_addr_hi = 4'b0101; strap_split = 1'b1;
    send(1'b0, 5'd0, 5'd2, 16'h0, cl, rd);
    check(cl && rd == pat(2), "R1 straps ignored after reset", rd, pat(2));
  endtask

  task automatic t_split;
    logic cl; logic [15:0] rd; int n;
    do_reset(4'b1000, 1'b1);
    send(1'b0, 5'd20, 5'd3, 16'h0, cl, rd);
    check(cl && rd == pat(4*32+3), "R3 upper half dev offset", rd, pat(4*32+3));
    send(1'b1, 5'd17, 5'd2, 16'h1357, cl, rd);
    @(negedge clk);
    check(mem[1*32+2] == 16'h1357, "R3 split write target", mem[1*32+2], 16'h1357);
    n = ib_count;
    send(1'b0, 5'd3, 5'd1, 16'h0, cl, rd);
    check(!cl && rd == 16'hFFFF, "R4 unclaimed read", {cl, rd}, 16'hFFFF);
    check(ib_count == n, "R4 no bus access", ib_count, n);
    do_reset(4'b0000, 1'b1);
    send(1'b0, 5'd18, 5'd0, 16'h0, cl, rd);
    check(!cl && rd == 16'hFFFF, "R3 lower half rejects upper", {cl, rd}, 16'hFFFF);
    send(1'b0, 5'd5, 5'd6, 16'h0, cl, rd);
    check(cl && rd == pat(5*32+6), "R3 lower half dev", rd, pat(5*32+6));
  endtask

  task automatic t_tunnel_basic;
    logic cl; logic [15:0] rd;
    logic [15:0] cmd;
    bit got [1:5];
    do_reset(4'b0011, 1'b0);
    send(1'b0, 5'd7, 5'd0, 16'h0, cl, rd);
    check(!cl && rd == 16'hFFFF, "R5 other address unclaimed", {cl, rd}, 16'hFFFF);
    send(1'b0, 5'd6, 5'd4, 16'h0, cl, rd);
    check(cl && rd == 16'h0000, "R5 spare register reads 0", rd, 0);
    cmd = 16'h8000 | 16'h1000 | (16'h2 << 10) | (16'd12 << 5) | 16'd5;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_phy = 5'd6; req_reg = 5'd0; req_wdata = cmd;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (i >= 3) got[i-2] = rsp_rdata[15];
      if (i <= 5) begin
        req_write = 0; req_reg = 5'd0;
      end else req_valid = 0;
    end
    for (int j = 1; j <= 5; j++)
      check(got[j] == (j <= LAT), "R7 busy window", got[j], (j <= LAT));
    send(1'b0, 5'd6, 5'd1, 16'h0, cl, rd);
    check(cl && rd == pat(12*32+5), "R9 read result in data reg", rd, pat(12*32+5));
    send(1'b0, 5'd6, 5'd0, 16'h0, cl, rd);
    check(rd == (cmd & 16'h7FFF), "R6 command readback", rd, cmd & 16'h7FFF);
  endtask

  task automatic t_tunnel_write;
    logic cl; logic [15:0] rd; int n;
    do_reset(4'b0011, 1'b0);
    n = ib_count;
    send(1'b1, 5'd6, 5'd1, 16'h4321, cl, rd);
    send(1'b1, 5'd6, 5'd0, 16'h9000 | (16'h1 << 10) | (16'd20 << 5) | 16'd7, cl, rd);
    poll_idle(5'd6, "R7 busy clears after write");
    check(mem[20*32+7] == 16'h4321, "R8 tunnelled write", mem[20*32+7], 16'h4321);
    check(ib_count == n + 1, "R8 single access", ib_count, n + 1);
  endtask

  task automatic t_tunnel_locks;
    logic cl; logic [15:0] rd; int n;
    logic [15:0] c1;
    do_reset(4'b0011, 1'b0);
    c1 = 16'h9000 | (16'h2 << 10) | (16'd1 << 5) | 16'd2;
    n = ib_count;
    send(1'b1, 5'd6, 5'd0, c1, cl, rd);
    send(1'b1, 5'd6, 5'd0, 16'h9000 | (16'h1 << 10) | (16'd3 << 5) | 16'd3, cl, rd);
    poll_idle(5'd6, "R11 idle");
    send(1'b0, 5'd6, 5'd1, 16'h0, cl, rd);
    check(rd == pat(1*32+2), "R11 first command ran", rd, pat(34));
    check(mem[3*32+3] == pat(99) && ib_count == n + 1, "R11 second command ignored",
          ib_count, n + 1);
    send(1'b0, 5'd6, 5'd0, 16'h0, cl, rd);
    check(rd == (c1 & 16'h7FFF), "R11 command reg kept", rd, c1 & 16'h7FFF);

    n = ib_count;
    send(1'b1, 5'd6, 5'd1, 16'h5A5A, cl, rd);
    send(1'b1, 5'd6, 5'd0, 16'h9000 | (16'h3 << 10) | 16'd1, cl, rd);
    send(1'b1, 5'd6, 5'd1, 16'h1111, cl, rd);
    poll_idle(5'd6, "R10 bad opcode clears busy");
    send(1'b0, 5'd6, 5'd1, 16'h0, cl, rd);
    check(rd == 16'h5A5A, "R12 data write while busy ignored", rd, 16'h5A5A);
    check(ib_count == n, "R10 bad opcode no access", ib_count, n);
    send(1'b1, 5'd6, 5'd0, 16'h8000 | (16'h2 << 10) | 16'd4, cl, rd);
    poll_idle(5'd6, "R10 idle");
    send(1'b0, 5'd6, 5'd1, 16'h0, cl, rd);
    check(rd == 16'h5A5A && ib_count == n, "R10 no clause-22 bit no access", rd, 16'h5A5A);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; strap_addr_hi = '0; strap_split = 0;
    req_valid = 0; req_write = 0; req_phy = '0; req_reg = '0; req_wdata = '0;
    t_reset();
    t_flat();
    t_split();
    t_tunnel_basic();
    t_tunnel_write();
    t_tunnel_locks();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule